// File: doc/BRIEF.md
# Four-State Add-Compare-Select Unit

This block is the per-stage path metric engine of a soft-decision Viterbi decoder for a four-state trellis carrying two information bits per step, at code rate two-thirds. Each trellis step delivers one 3-symbol received word. An upstream stage has already turned that word into four branch metrics. Each metric is a soft Euclidean distance formed from 3-bit (8-level) quantized samples, and it is already minimized over the parallel branches of its transition subset. The subset is named by the two encoder output bits that depend on the state.

For each next state, the unit adds the two incoming branch metrics to the stored metrics of that state's two predecessors. It keeps the smaller of the two sums and records which predecessor won as one decision bit, which goes to an external survivor memory. It also reports the state that now holds the smallest metric, which is where a traceback starts. When every metric has climbed past half of its range, the smallest one is subtracted from all four, so the stored values stay bounded without changing any comparison.

The state index is `{older_bit, newest_bit}`, where the bits are the two most recent values of the coded information bit. The next state is `{s[0], u}` for the newest bit `u`.

Top module: `vit_acs4`

## Requirements
- R1: While `rst_ni` is low, and after it rises until the first accepted word, `pm_o` holds 0 for state 0 and 2^(PM_W-2) for states 1 to 3, `valid_o` is 0, `dec_o` is 0 and `min_state_o` is 0.
- R2: For next state n, with u = n[0] and h = n[1], the predecessors are state {0,h} and state {1,h}. The branch code for predecessor {0,h} is {u,h}, and the branch code for predecessor {1,h} is {~u,h}. The metric for branch code c sits in `bm_i[c*BM_W +: BM_W]`. Each candidate is the predecessor's stored metric plus the metric of its branch code.
- R3: Each state keeps the smaller candidate. `dec_o[n]` is 1 when predecessor {1,h} was kept and 0 when {0,h} was kept. When the two candidates are equal, the decision bit is 0.
- R4: `min_state_o` is the index of the smallest newly stored metric. When several states share that value, the lowest index is reported.
- R5: If every newly selected metric is at least 2^(PM_W-1), the smallest of them is subtracted from all four before they are stored. Otherwise the metrics are stored unchanged. As a result, no stored set ever has all four most significant bits set.
- R6: `valid_o`, `dec_o`, `min_state_o` and `pm_o` are registered. They reflect a word presented with `valid_i` high in the cycle that immediately follows it, and `valid_o` is high only in that cycle.
- R7: A cycle with `valid_i` low leaves `pm_o`, `dec_o` and `min_state_o` unchanged and drives `valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A new set of branch metrics is presented |
| bm_i | input | 4*BM_W | Branch metric per transition subset, slot c = branch code c |
| valid_o | output | 1 | Decisions and metrics of a new step are available |
| dec_o | output | 4 | Survivor decision per next state, bit n for state n |
| min_state_o | output | 2 | State holding the smallest metric |
| pm_o | output | 4*PM_W | Stored path metrics, state n at bits [n*PM_W +: PM_W] |

## Verification
The first word after reset is sent with a hand-derived branch set. Its expected results separate the two predecessor wirings and the two branch-code mappings, and it also exercises a two-way tie for the minimum state. Candidate ties at a state and a strictly smaller upper-predecessor candidate are tried separately, which tells the tie-breaking rule apart from the ordinary compare. A run of identical maximum branch metrics drives every state past the half-range threshold at the same step, where the expected result is four zeros. A long pseudo-random stream with idle gaps is compared step by step against an independent trellis model, which exposes wrong predecessors, wrong codes, an inverted compare and any change of state during idle cycles.

// File: rtl/vit_acs_pkg.sv
package vit_acs_pkg;
  localparam int NSTATE = 4;
  localparam int SW     = 2;

  typedef logic [SW-1:0] state_t;

  // predecessor of next state ns; sel picks the older-bit value
  function automatic state_t pred_state(state_t ns, logic sel);
    return {sel, ns[1]};
  endfunction

  // transition subset code {y1, y0} for the branch pred_state(ns, sel) -> ns
  function automatic logic [1:0] branch_code(state_t ns, logic sel);
    return {ns[0] ^ sel, ns[1]};
  endfunction
endpackage

// File: rtl/vit_acs_node.sv
module vit_acs_node #(
  parameter int PM_W = 8,
  parameter int BM_W = 5,
  localparam int SUM_W = PM_W + 1
) (
  input  logic [PM_W-1:0]  pm_lo_i,
  input  logic [PM_W-1:0]  pm_hi_i,
  input  logic [BM_W-1:0]  bm_lo_i,
  input  logic [BM_W-1:0]  bm_hi_i,
  output logic [SUM_W-1:0] sum_o,
  output logic             dec_o
);
  logic [SUM_W-1:0] cand_lo, cand_hi;

  assign cand_lo = {1'b0, pm_lo_i} + SUM_W'(bm_lo_i);
  assign cand_hi = {1'b0, pm_hi_i} + SUM_W'(bm_hi_i);

  // strict compare: a tie keeps the lower-numbered predecessor
  assign dec_o = cand_hi < cand_lo;
  assign sum_o = dec_o ? cand_hi : cand_lo;
endmodule

// File: rtl/vit_acs_minsel.sv
module vit_acs_minsel #(
  parameter int N  = 4,
  parameter int W  = 9,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][W-1:0] vals_i,
  output logic [W-1:0]        min_o,
  output logic [IW-1:0]       idx_o
);
  always_comb begin
    min_o = vals_i[0];
    idx_o = '0;
    for (int i = 1; i < N; i++) begin
      if (vals_i[i] < min_o) begin
        min_o = vals_i[i];
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vit_acs_norm.sv
module vit_acs_norm #(
  parameter int N     = 4,
  parameter int W_IN  = 9,
  parameter int W_OUT = 8
) (
  input  logic [N-1:0][W_IN-1:0]  vals_i,
  input  logic [W_IN-1:0]         min_i,
  output logic [N-1:0][W_OUT-1:0] vals_o
);
  localparam logic [W_IN-1:0] HALF = W_IN'(1) << (W_OUT - 1);

  logic [N-1:0] above;
  logic         shift;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign above[g] = vals_i[g] >= HALF;
  end

  assign shift = &above;

  for (genvar g = 0; g < N; g++) begin : g_out
    logic [W_IN-1:0] diff;
    assign diff      = vals_i[g] - min_i;
    assign vals_o[g] = shift ? W_OUT'(diff) : W_OUT'(vals_i[g]);
  end
endmodule

// File: rtl/vit_acs4.sv
module vit_acs4
  import vit_acs_pkg::*;
#(
  parameter int BM_W = 5,
  parameter int PM_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [NSTATE*BM_W-1:0]   bm_i,
  output logic                     valid_o,
  output logic [NSTATE-1:0]        dec_o,
  output logic [SW-1:0]            min_state_o,
  output logic [NSTATE*PM_W-1:0]   pm_o
);
  localparam int SUM_W = PM_W + 1;
  localparam logic [PM_W-1:0] PM_INIT = PM_W'(1) << (PM_W - 2);

  logic [NSTATE-1:0][BM_W-1:0]  bm;
  logic [NSTATE-1:0][PM_W-1:0]  pm_q, pm_next;
  logic [NSTATE-1:0][SUM_W-1:0] sum;
  logic [NSTATE-1:0]            dec_next;
  logic [SUM_W-1:0]             sum_min;
  logic [SW-1:0]                min_idx;

  for (genvar c = 0; c < NSTATE; c++) begin : g_bm
    assign bm[c] = bm_i[c*BM_W +: BM_W];
  end

  for (genvar n = 0; n < NSTATE; n++) begin : g_acs
    localparam state_t     P_LO = pred_state(state_t'(n), 1'b0);
    localparam state_t     P_HI = pred_state(state_t'(n), 1'b1);
    localparam logic [1:0] C_LO = branch_code(state_t'(n), 1'b0);
    localparam logic [1:0] C_HI = branch_code(state_t'(n), 1'b1);

    vit_acs_node #(.PM_W(PM_W), .BM_W(BM_W)) u_node (
      .pm_lo_i (pm_q[P_LO]),
      .pm_hi_i (pm_q[P_HI]),
      .bm_lo_i (bm[C_LO]),
      .bm_hi_i (bm[C_HI]),
      .sum_o   (sum[n]),
      .dec_o   (dec_next[n])
    );
  end

  vit_acs_minsel #(.N(NSTATE), .W(SUM_W)) u_min (
    .vals_i (sum),
    .min_o  (sum_min),
    .idx_o  (min_idx)
  );

  vit_acs_norm #(.N(NSTATE), .W_IN(SUM_W), .W_OUT(PM_W)) u_norm (
    .vals_i (sum),
    .min_i  (sum_min),
    .vals_o (pm_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSTATE; i++) pm_q[i] <= (i == 0) ? '0 : PM_INIT;
      dec_o       <= '0;
      min_state_o <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        pm_q        <= pm_next;
        dec_o       <= dec_next;
        min_state_o <= min_idx;
      end
    end
  end

  for (genvar n = 0; n < NSTATE; n++) begin : g_pm_out
    assign pm_o[n*PM_W +: PM_W] = pm_q[n];
  end
endmodule

// File: rtl/vit_acs4_chk.sv
module vit_acs4_chk
  import vit_acs_pkg::*;
#(
  parameter int PM_W = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   valid_i,
  input logic                   valid_o,
  input logic [NSTATE-1:0]      dec_o,
  input logic [SW-1:0]          min_state_o,
  input logic [NSTATE*PM_W-1:0] pm_o
);
  logic [NSTATE-1:0][PM_W-1:0] pm;
  logic [NSTATE-1:0]           msb;
  logic [PM_W-1:0]             pm_min;
  logic                        min_ok;

  for (genvar n = 0; n < NSTATE; n++) begin : g_unpack
    assign pm[n]  = pm_o[n*PM_W +: PM_W];
    assign msb[n] = pm[n][PM_W-1];
  end

  assign pm_min = pm[min_state_o];

  always_comb begin
    min_ok = 1'b1;
    for (int k = 0; k < NSTATE; k++) begin
      if (pm[k] < pm_min) min_ok = 1'b0;
      if (k < int'(min_state_o) && pm[k] == pm_min) min_ok = 1'b0;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(pm_o) && $stable(dec_o) && $stable(min_state_o)); // R7

  AST_MIN_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> min_ok); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(&msb)); // R5
endmodule

bind vit_acs4 vit_acs4_chk #(.PM_W(PM_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .valid_o     (valid_o),
  .dec_o       (dec_o),
  .min_state_o (min_state_o),
  .pm_o        (pm_o)
);

// File: tb/tb_vit_acs4.sv
module tb_vit_acs4;
  localparam int CLK_PERIOD = 10;
  localparam int BM_W = 5;
  localparam int PM_W = 8;
  localparam int NS   = 4;
  localparam int INIT = 1 << (PM_W - 2);
  localparam int HALF = 1 << (PM_W - 1);
  localparam int WATCHDOG = 100000;

  logic                 clk_i = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 valid_i = 1'b0;
  logic [NS*BM_W-1:0]   bm_i = '0;
  logic                 valid_o;
  logic [NS-1:0]        dec_o;
  logic [1:0]           min_state_o;
  logic [NS*PM_W-1:0]   pm_o;

  int n_vec = 0;
  int n_err = 0;
  int mdl_pm [NS];
  int mdl_dec;
  int mdl_min;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  vit_acs4 #(.BM_W(BM_W), .PM_W(PM_W)) dut (
    .clk_i, .rst_ni, .valid_i, .bm_i, .valid_o, .dec_o, .min_state_o, .pm_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(string req, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pm_at(int n);
    return int'(pm_o[n*PM_W +: PM_W]);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NS; i++) mdl_pm[i] = (i == 0) ? 0 : INIT;
    mdl_dec = 0;
    mdl_min = 0;
  endtask

  // reference trellis step built from R2..R5
  task automatic model_step(int b0, int b1, int b2, int b3);
    int bm [NS];
    int nw [NS];
    int mn;
    bm[0] = b0; bm[1] = b1; bm[2] = b2; bm[3] = b3;
    mdl_dec = 0;
    for (int n = 0; n < NS; n++) begin
      int u = n & 1;
      int h = n >> 1;
      int a = mdl_pm[h] + bm[(u << 1) | h];
      int b = mdl_pm[2 | h] + bm[((u ^ 1) << 1) | h];
      if (b < a) begin nw[n] = b; mdl_dec |= (1 << n); end
      else nw[n] = a;
    end
    mn = nw[0];
    mdl_min = 0;
    for (int n = 1; n < NS; n++) if (nw[n] < mn) begin mn = nw[n]; mdl_min = n; end
    if (nw[0] >= HALF && nw[1] >= HALF && nw[2] >= HALF && nw[3] >= HALF)
      for (int n = 0; n < NS; n++) nw[n] -= mn;
    for (int n = 0; n < NS; n++) mdl_pm[n] = nw[n];
  endtask

  task automatic check_model(string tag);
    for (int n = 0; n < NS; n++) chk("R2/R5", $sformatf("%s pm[%0d]", tag, n), pm_at(n), mdl_pm[n]);
    chk("R3", {tag, " dec"}, int'(dec_o), mdl_dec);
    chk("R4", {tag, " min_state"}, int'(min_state_o), mdl_min);
  endtask

  // called at a negedge; returns at the negedge after the capturing edge
  task automatic step(string tag, int b0, int b1, int b2, int b3);
    bm_i    = {BM_W'(b3), BM_W'(b2), BM_W'(b1), BM_W'(b0)};
    valid_i = 1'b1;
    model_step(b0, b1, b2, b3);
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R6", {tag, " valid_o"}, int'(valid_o), 1);
    check_model(tag);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni  = 1'b0;
    valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R1", "in-reset pm[0]", pm_at(0), 0);
    chk("R1", "in-reset pm[3]", pm_at(3), INIT);
    rst_ni = 1'b1;
    model_reset();
    @(negedge clk_i);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1", "valid_o", int'(valid_o), 0);
    chk("R1", "dec_o", int'(dec_o), 0);
    chk("R1", "min_state_o", int'(min_state_o), 0);
    for (int n = 0; n < NS; n++) chk("R1", $sformatf("pm[%0d]", n), pm_at(n), (n == 0) ? 0 : INIT);
  endtask

  task automatic t_first_word();
    do_reset();
    // code 1 and 3 feed states 2,3; code 0 and 2 feed states 0,1
    step("R2 first", 0, 5, 0, 2);
    chk("R2", "explicit pm[1]", pm_at(1), 0);
    chk("R2", "explicit pm[2]", pm_at(2), INIT + 2);
    chk("R3", "explicit dec (upper wins at state 2)", int'(dec_o), 4'b0100);
    chk("R4", "explicit min tie -> 0", int'(min_state_o), 0);
  endtask

  task automatic t_tie_rule();
    do_reset();
    step("R3 tie", 3, 7, 3, 7);
    chk("R3", "equal candidates keep lower predecessor", int'(dec_o), 0);
    step("R3 follow", 9, 1, 0, 4);
  endtask

  task automatic t_idle_hold();
    int snap [NS];
    int sd, sm;
    step("R7 pre", 4, 2, 6, 1);
    for (int n = 0; n < NS; n++) snap[n] = pm_at(n);
    sd = int'(dec_o);
    sm = int'(min_state_o);
    bm_i = '1;
    repeat (3) @(negedge clk_i);
    chk("R7", "valid_o idle", int'(valid_o), 0);
    chk("R7", "dec_o idle", int'(dec_o), sd);
    chk("R7", "min_state idle", int'(min_state_o), sm);
    for (int n = 0; n < NS; n++) chk("R7", $sformatf("pm[%0d] idle", n), pm_at(n), snap[n]);
  endtask

  task automatic t_normalize();
    do_reset();
    for (int i = 0; i < 4; i++) step("R5 climb", 31, 31, 31, 31);
    chk("R5", "below threshold pm[0]", pm_at(0), 124);
    step("R5 crossing", 31, 31, 31, 31);
    for (int n = 0; n < NS; n++) chk("R5", $sformatf("normalized pm[%0d]", n), pm_at(n), 0);
  endtask

  task automatic t_random(int count);
    for (int i = 0; i < count; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[0] & lfsr[7]) begin
        @(negedge clk_i);
        chk("R7", "random idle valid_o", int'(valid_o), 0);
      end else begin
        step("R2 random", int'(lfsr[4:0]), int'(lfsr[9:5]), int'(lfsr[14:10]),
             int'({lfsr[15], lfsr[3:0]}));
      end
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      n_vec++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    model_reset();
    t_reset_state();
    t_first_word();
    t_tie_rule();
    t_idle_hold();
    t_normalize();
    t_random(600);
    t_reset_state();
    t_random(200);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule